// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Two SRAM Controller

This controller connects a user request interface to an external synchronous static memory that has a separate read data bus and a separate write data bus. One address bus is shared by both ports. Each memory clock cycle has two half-cycle slots. The read address is presented in the first slot (K edge) and the write address in the second slot (K# edge). A read and a write can therefore both be issued in the same memory cycle, and no bus ever turns around. Every access moves a pair of words at double data rate.

The design runs on one internal clock at twice the memory clock rate, so one internal tick is one memory half-cycle. A three-state machine steps through the slots:
- `ST_RST` is held while reset is asserted and for one tick after release. It then moves to `ST_KSLOT`.
- `ST_KSLOT` is the tick in which user requests are accepted. It always moves to `ST_KBSLOT`.
- `ST_KBSLOT` always moves back to `ST_KSLOT`.
- Reset returns the machine to `ST_RST` from any state.

Each request is registered onto the memory pins in the tick after it is accepted. Read data returns on `mem_q_i` after a fixed latency, which a static mode input selects. A capture pipeline driven by the issued read selects collects the two words. The pair is then reported with a one-tick valid pulse and an in-order tag.

Top module: `qdr_b2_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_rps_n_o` and `mem_wps_n_o` are 1, `rsp_valid_o` is 0 and both ready outputs are 0.
- R2: After reset, both ready outputs are 1 on every second tick and 0 on the other ticks. In the tick after a ready tick, `mem_kph_o` is 0 (K slot). In the tick after that, `mem_kph_o` is 1 (K# slot). Handshakes complete only on ready ticks.
- R3: An accepted read drives `mem_rps_n_o` low and `mem_addr_o` to the read address in the K-slot tick that follows acceptance. `mem_rps_n_o` is high in every K# slot.
- R4: An accepted write drives `mem_wps_n_o` low in both ticks of the following memory cycle. In the K slot, `mem_d_o` carries word 0. In the K# slot, `mem_addr_o` carries the write address and `mem_d_o` carries word 1.
- R5: A read and a write accepted in the same ready tick are both issued in the same memory cycle: the read in its K slot and the write in its K# slot.
- R6: A port with no accepted request keeps its select high for the whole memory cycle, so the memory array is left unchanged.
- R7: With `dll_off_i`=0, the memory delivers word 0 on `mem_q_i` 3 ticks after the K edge that sampled the read, and word 1 one tick later. `rsp_valid_o` rises 5 ticks after the tick in which `mem_rps_n_o` was low.
- R8: With `dll_off_i`=1, the memory latency is 2 ticks, and `rsp_valid_o` rises 4 ticks after the read-select tick.
- R9: `rsp_valid_o` is high for exactly one tick per issued read. While it is high, `rsp_data0_o` holds the word captured first and `rsp_data1_o` holds the word captured second.
- R10: `rsp_tag_o` counts responses from 0 after reset, in request order, and wraps modulo 2^TAGW.
- R11: A read accepted in the memory cycle after a write to the same address returns the new data. A read accepted in the same cycle as a write to its address returns the old data, because the read slot comes first.
- R12: `mem_bws_n_o` is all zeros (every byte lane enabled) whenever `mem_wps_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dll_off_i | input | 1 | Static latency mode: 0 = 1.5-cycle, 1 = 1-cycle |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request accepted in this tick when valid |
| rd_addr_i | input | AW | Read address |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request accepted in this tick when valid |
| wr_addr_i | input | AW | Write address |
| wr_data0_i | input | DW | First word of the write pair |
| wr_data1_i | input | DW | Second word of the write pair |
| mem_kph_o | output | 1 | Slot marker: 0 = K slot, 1 = K# slot |
| mem_addr_o | output | AW | Shared memory address bus |
| mem_rps_n_o | output | 1 | Active-low read port select |
| mem_wps_n_o | output | 1 | Active-low write port select |
| mem_d_o | output | DW | Memory write data bus |
| mem_bws_n_o | output | BWN | Active-low byte-write selects |
| mem_q_i | input | DW | Memory read data bus |
| rsp_valid_o | output | 1 | Read pair valid for one tick |
| rsp_data0_o | output | DW | First word of the read pair |
| rsp_data1_o | output | DW | Second word of the read pair |
| rsp_tag_o | output | TAGW | In-order response tag |

## Verification
The bench probes the exact tick of data capture in both latency modes. A capture tap that is off by one would return a neighbouring word or bus noise, and the latency count would differ from 5 or 4. It sends write-then-read and same-cycle read-plus-write pairs to one address. A controller that swapped the slot order, or dropped the write when a read was issued alongside it, would return the wrong generation of data. It also checks that word 0 and word 1 appear in their own slots and that selects stay high on idle ports. Swapped words or a stray select would corrupt the model memory and show up in later reads.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

    // Slot sequencer states: one internal tick per memory half-cycle.
    typedef enum logic [1:0] {
        ST_RST    = 2'd0,
        ST_KSLOT  = 2'd1,
        ST_KBSLOT = 2'd2
    } slot_e;

    // Memory read latency in internal ticks, from the K edge to word 0.
    localparam int LAT_NORMAL  = 3;
    localparam int LAT_DLL_OFF = 2;

    // Byte-write lane count for the supported word widths.
    function automatic int lane_count(input int dw);
        return (dw > 9) ? dw / 9 : 1;
    endfunction

endpackage

// File: rtl/qdr_b2_sched.sv
module qdr_b2_sched
    import qdr_b2_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic          wr_valid_i,
    input  logic [AW-1:0] wr_addr_i,
    output logic          accept_o,
    output logic          wr_fire_o,
    output logic          second_o,
    output logic          kph_o,
    output logic [AW-1:0] addr_o,
    output logic          rps_n_o,
    output logic          wps_n_o
);

    slot_e         st_q;
    slot_e         st_nx;
    logic          rd_fire;
    logic          wr_pend_q;
    logic [AW-1:0] wr_addr_q;

    assign accept_o  = (st_q == ST_KSLOT);
    assign rd_fire   = accept_o & rd_valid_i;
    assign wr_fire_o = accept_o & wr_valid_i;
    assign second_o  = (st_q == ST_KBSLOT);

    // Next-state logic.
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_RST:    st_nx = ST_KSLOT;
            ST_KSLOT:  st_nx = ST_KBSLOT;
            ST_KBSLOT: st_nx = ST_KSLOT;
            default:   st_nx = ST_RST;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_nx;
        end
    end

    // Registered memory command outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kph_o     <= 1'b1;
            addr_o    <= '0;
            rps_n_o   <= 1'b1;
            wps_n_o   <= 1'b1;
            wr_pend_q <= 1'b0;
            wr_addr_q <= '0;
        end else begin
            unique case (st_q)
                ST_KSLOT: begin
                    // Outputs for the K slot: read address, write word 0.
                    kph_o     <= 1'b0;
                    rps_n_o   <= ~rd_fire;
                    wps_n_o   <= ~wr_fire_o;
                    wr_pend_q <= wr_fire_o;
                    if (rd_fire) begin
                        addr_o <= rd_addr_i;
                    end
                    if (wr_fire_o) begin
                        wr_addr_q <= wr_addr_i;
                    end
                end
                ST_KBSLOT: begin
                    // Outputs for the K# slot: write address, write word 1.
                    kph_o     <= 1'b1;
                    rps_n_o   <= 1'b1;
                    wps_n_o   <= ~wr_pend_q;
                    wr_pend_q <= 1'b0;
                    if (wr_pend_q) begin
                        addr_o <= wr_addr_q;
                    end
                end
                default: begin
                    kph_o     <= 1'b1;
                    rps_n_o   <= 1'b1;
                    wps_n_o   <= 1'b1;
                    wr_pend_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/qdr_b2_wrdata.sv
module qdr_b2_wrdata #(
    parameter int DW  = 18,
    parameter int BWN = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           second_i,
    input  logic [DW-1:0]  w0_i,
    input  logic [DW-1:0]  w1_i,
    output logic [DW-1:0]  d_o,
    output logic [BWN-1:0] bws_n_o
);

    logic [DW-1:0] w1_q;

    // Word 0 goes out with the K slot, word 1 is parked for the K# slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_o  <= '0;
            w1_q <= '0;
        end else if (load_i) begin
            d_o  <= w0_i;
            w1_q <= w1_i;
        end else if (second_i) begin
            d_o  <= w1_q;
        end
    end

    // Every byte lane is written on every write.
    for (genvar g = 0; g < BWN; g++) begin : g_lane
        assign bws_n_o[g] = 1'b0;
    end

endmodule

// File: rtl/qdr_b2_rdcap.sv
module qdr_b2_rdcap
    import qdr_b2_pkg::*;
#(
    parameter int DW   = 18,
    parameter int TAGW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dll_off_i,
    input  logic            rps_n_i,
    input  logic            kph_i,
    input  logic [DW-1:0]   q_i,
    output logic            valid_o,
    output logic [DW-1:0]   d0_o,
    output logic [DW-1:0]   d1_o,
    output logic [TAGW-1:0] tag_o
);

    localparam int PIPE = LAT_NORMAL + 1;

    logic [PIPE-1:0] pipe_q;
    logic            cap0;
    logic            cap1;
    logic [TAGW-1:0] tag_cnt_q;

    // Issue marker travels one stage per tick after the sampling K edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE-2:0], ~rps_n_i & ~kph_i};
        end
    end

    assign cap0 = dll_off_i ? pipe_q[LAT_DLL_OFF-1] : pipe_q[LAT_NORMAL-1];
    assign cap1 = dll_off_i ? pipe_q[LAT_DLL_OFF]   : pipe_q[LAT_NORMAL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            d0_o      <= '0;
            d1_o      <= '0;
            tag_o     <= '0;
            tag_cnt_q <= '0;
        end else begin
            valid_o <= cap1;
            if (cap0) begin
                d0_o <= q_i;
            end
            if (cap1) begin
                d1_o      <= q_i;
                tag_o     <= tag_cnt_q;
                tag_cnt_q <= tag_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/qdr_b2_ctrl.sv
module qdr_b2_ctrl
    import qdr_b2_pkg::*;
#(
    parameter  int AW   = 20,
    parameter  int DW   = 18,
    parameter  int TAGW = 4,
    localparam int BWN  = lane_count(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dll_off_i,
    input  logic            rd_valid_i,
    output logic            rd_ready_o,
    input  logic [AW-1:0]   rd_addr_i,
    input  logic            wr_valid_i,
    output logic            wr_ready_o,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [DW-1:0]   wr_data0_i,
    input  logic [DW-1:0]   wr_data1_i,
    output logic            mem_kph_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic            mem_rps_n_o,
    output logic            mem_wps_n_o,
    output logic [DW-1:0]   mem_d_o,
    output logic [BWN-1:0]  mem_bws_n_o,
    input  logic [DW-1:0]   mem_q_i,
    output logic            rsp_valid_o,
    output logic [DW-1:0]   rsp_data0_o,
    output logic [DW-1:0]   rsp_data1_o,
    output logic [TAGW-1:0] rsp_tag_o
);

    logic accept;
    logic wr_fire;
    logic second;

    assign rd_ready_o = accept;
    assign wr_ready_o = accept;

    qdr_b2_sched #(.AW(AW)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_valid_i (rd_valid_i),
        .rd_addr_i  (rd_addr_i),
        .wr_valid_i (wr_valid_i),
        .wr_addr_i  (wr_addr_i),
        .accept_o   (accept),
        .wr_fire_o  (wr_fire),
        .second_o   (second),
        .kph_o      (mem_kph_o),
        .addr_o     (mem_addr_o),
        .rps_n_o    (mem_rps_n_o),
        .wps_n_o    (mem_wps_n_o)
    );

    qdr_b2_wrdata #(.DW(DW), .BWN(BWN)) u_wrdata (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (wr_fire),
        .second_i (second),
        .w0_i     (wr_data0_i),
        .w1_i     (wr_data1_i),
        .d_o      (mem_d_o),
        .bws_n_o  (mem_bws_n_o)
    );

    qdr_b2_rdcap #(.DW(DW), .TAGW(TAGW)) u_rdcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .dll_off_i (dll_off_i),
        .rps_n_i   (mem_rps_n_o),
        .kph_i     (mem_kph_o),
        .q_i       (mem_q_i),
        .valid_o   (rsp_valid_o),
        .d0_o      (rsp_data0_o),
        .d1_o      (rsp_data1_o),
        .tag_o     (rsp_tag_o)
    );

endmodule

// File: rtl/qdr_b2_chk.sv
module qdr_b2_chk (
    input logic clk,
    input logic rst_n,
    input logic dll_off_i,
    input logic rd_ready_o,
    input logic mem_kph_o,
    input logic mem_rps_n_o,
    input logic mem_wps_n_o,
    input logic rsp_valid_o
);

    logic [3:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 4'hF) begin
            since_rst_q <= since_rst_q + 1'b1;
        end
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (mem_rps_n_o && mem_wps_n_o && !rsp_valid_o && !rd_ready_o);
        end
    end

    a_r2_ready_then_k: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready_o |=> (!mem_kph_o && !rd_ready_o));

    a_r2_k_then_kb: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_kph_o |=> mem_kph_o);

    a_r3_read_in_k: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rps_n_o |-> !mem_kph_o);

    a_r4_write_spans_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wps_n_o && !mem_kph_o) |=> !mem_wps_n_o);

    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    a_r7_latency_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q > 4'd6 && !dll_off_i && !$past(mem_rps_n_o, 5)) |-> rsp_valid_o);

    a_r8_latency_dll_off: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q > 4'd6 && dll_off_i && !$past(mem_rps_n_o, 4)) |-> rsp_valid_o);

endmodule

bind qdr_b2_ctrl qdr_b2_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dll_off_i   (dll_off_i),
    .rd_ready_o  (rd_ready_o),
    .mem_kph_o   (mem_kph_o),
    .mem_rps_n_o (mem_rps_n_o),
    .mem_wps_n_o (mem_wps_n_o),
    .rsp_valid_o (rsp_valid_o)
);

// File: tb/qdr_b2_ctrl_tb_top.sv
module qdr_b2_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 20;
    localparam int DW   = 18;
    localparam int TAGW = 4;
    localparam int BWN  = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dll_off_i;
    logic            rd_valid_i;
    logic            rd_ready_o;
    logic [AW-1:0]   rd_addr_i;
    logic            wr_valid_i;
    logic            wr_ready_o;
    logic [AW-1:0]   wr_addr_i;
    logic [DW-1:0]   wr_data0_i;
    logic [DW-1:0]   wr_data1_i;
    logic            mem_kph_o;
    logic [AW-1:0]   mem_addr_o;
    logic            mem_rps_n_o;
    logic            mem_wps_n_o;
    logic [DW-1:0]   mem_d_o;
    logic [BWN-1:0]  mem_bws_n_o;
    logic [DW-1:0]   mem_q_i = '0;
    logic            rsp_valid_o;
    logic [DW-1:0]   rsp_data0_o;
    logic [DW-1:0]   rsp_data1_o;
    logic [TAGW-1:0] rsp_tag_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdr_b2_ctrl #(.AW(AW), .DW(DW), .TAGW(TAGW)) dut_i (.*);

    int n_chk  = 0;
    int n_fail = 0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at tick %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_lat(input logic dll);
        return dll ? 4 : 5;
    endfunction

    // Memory model: read snapshot at K edge, write committed at K# edge.
    logic [DW-1:0] mdl0 [16] = '{default: '0};
    logic [DW-1:0] mdl1 [16] = '{default: '0};
    logic [DW-1:0] wbuf = '0;
    logic [3:0]    rq_v = '0;
    logic [DW-1:0] rq0 [4] = '{default: '0};
    logic [DW-1:0] rq1 [4] = '{default: '0};

    always @(posedge clk) begin
        int lat;
        lat = dll_off_i ? 2 : 3;
        for (int i = 3; i > 0; i--) begin
            rq0[i] <= rq0[i-1];
            rq1[i] <= rq1[i-1];
        end
        rq_v <= {rq_v[2:0], (!mem_rps_n_o && !mem_kph_o)};
        rq0[0] <= mdl0[mem_addr_o[3:0]];
        rq1[0] <= mdl1[mem_addr_o[3:0]];
        if (!mem_kph_o) wbuf <= mem_d_o;
        if (mem_kph_o && !mem_wps_n_o) begin
            mdl0[mem_addr_o[3:0]] <= wbuf;
            mdl1[mem_addr_o[3:0]] <= mem_d_o;
        end
        if (rq_v[lat-2])      mem_q_i <= rq0[lat-2];
        else if (rq_v[lat-1]) mem_q_i <= rq1[lat-1];
        else                  mem_q_i <= DW'($urandom);
    end

    // Bench reference state and expectations.
    logic [DW-1:0] ref0 [16] = '{default: '0};
    logic [DW-1:0] ref1 [16] = '{default: '0};
    logic [DW-1:0] exp0_q [$];
    logic [DW-1:0] exp1_q [$];
    string         lbl_q [$];
    longint        iss_q [$];
    logic [TAGW-1:0] tag_exp = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            tag_exp = '0;
            iss_q.delete();
        end else begin
            if (!mem_rps_n_o && !mem_kph_o) iss_q.push_back(cyc);
            if (rsp_valid_o) begin
                if (exp0_q.size() == 0 || iss_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected response", 1, 0);
                end else begin
                    logic [DW-1:0] e0, e1;
                    string lb;
                    longint t0;
                    e0 = exp0_q.pop_front();
                    e1 = exp1_q.pop_front();
                    lb = lbl_q.pop_front();
                    t0 = iss_q.pop_front();
                    chk(rsp_data0_o == e0, {lb, " word0"}, rsp_data0_o, e0);
                    chk(rsp_data1_o == e1, {lb, " word1"}, rsp_data1_o, e1);
                    chk(cyc - t0 == exp_lat(dll_off_i), dll_off_i ? "R8 latency" : "R7 latency",
                        cyc - t0, exp_lat(dll_off_i));
                    chk(rsp_tag_o == tag_exp, "R10 tag", rsp_tag_o, tag_exp);
                    tag_exp = tag_exp + 1'b1;
                end
            end
        end
    end

    // One memory cycle: entered at a negedge in a ready tick, leaves at the next one.
    task automatic mem_cycle(input bit rv, input int ra, input bit wv, input int wa,
                             input logic [DW-1:0] w0, input logic [DW-1:0] w1, input string lb);
        chk(rd_ready_o && wr_ready_o, "R2 ready", rd_ready_o, 1);
        rd_valid_i = rv; rd_addr_i = AW'(ra);
        wr_valid_i = wv; wr_addr_i = AW'(wa);
        wr_data0_i = w0; wr_data1_i = w1;
        if (rv) begin
            exp0_q.push_back(ref0[ra]);
            exp1_q.push_back(ref1[ra]);
            lbl_q.push_back(lb);
        end
        if (wv) begin
            ref0[wa] = w0;
            ref1[wa] = w1;
        end
        @(negedge clk);
        rd_valid_i = 1'b0; wr_valid_i = 1'b0;
        chk(!mem_kph_o && !rd_ready_o, "R2 K slot", {mem_kph_o, rd_ready_o}, 0);
        chk(mem_rps_n_o == !rv, rv ? "R3 read select" : "R6 read idle", mem_rps_n_o, !rv);
        if (rv) chk(mem_addr_o == AW'(ra), "R3 read addr", mem_addr_o, ra);
        chk(mem_wps_n_o == !wv, wv ? "R4 write select K" : "R6 write idle", mem_wps_n_o, !wv);
        if (wv) chk(mem_d_o == w0, "R4 word0", mem_d_o, w0);
        if (wv) chk(mem_bws_n_o == '0, "R12 byte enables", mem_bws_n_o, 0);
        @(negedge clk);
        chk(mem_kph_o && mem_rps_n_o, "R3 K# slot no read", {mem_kph_o, mem_rps_n_o}, 3);
        chk(mem_wps_n_o == !wv, wv ? "R5 write select K#" : "R6 write idle K#", mem_wps_n_o, !wv);
        if (wv) chk(mem_addr_o == AW'(wa), "R4 write addr", mem_addr_o, wa);
        if (wv) chk(mem_d_o == w1, "R4 word1", mem_d_o, w1);
    endtask

    task automatic do_reset(input logic dll);
        @(negedge clk);
        rst_n = 1'b0; dll_off_i = dll;
        rd_valid_i = 1'b0; wr_valid_i = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(mem_rps_n_o && mem_wps_n_o && !rsp_valid_o && !rd_ready_o && !wr_ready_o,
                "R1 reset idle", {mem_rps_n_o, mem_wps_n_o, rsp_valid_o, rd_ready_o}, 4'hC);
        end
        rst_n = 1'b1;
        @(negedge clk);
        while (!rd_ready_o) @(negedge clk);
    endtask

    task automatic run_mode(input logic dll);
        do_reset(dll);
        // Coherency: write then read next cycle gets new data.
        mem_cycle(0, 0, 1, 5, 18'h1A5A5, 18'h05A5A, "R11");
        mem_cycle(1, 5, 0, 0, 0, 0, "R11 new data");
        // Same-cycle read and write to one address returns old data.
        mem_cycle(0, 0, 1, 6, 18'h11111, 18'h22222, "R11");
        mem_cycle(1, 6, 1, 6, 18'h33333, 18'h34444, "R5 R11 old data");
        mem_cycle(1, 6, 0, 0, 0, 0, "R11 new data");
        // Idle cycle must not touch the array.
        mem_cycle(0, 0, 0, 0, 18'h3FFFF, 18'h3FFFF, "R6");
        mem_cycle(1, 6, 0, 0, 0, 0, "R6 unchanged");
        // Back-to-back reads across the tag wrap.
        for (int i = 0; i < 20; i++) mem_cycle(1, i % 16, 0, 0, 0, 0, "R9 R10 stream");
        for (int i = 0; i < 250; i++) begin
            mem_cycle($urandom % 2, $urandom % 16, $urandom % 2, $urandom % 16,
                      DW'($urandom), DW'($urandom), "R9 random");
        end
        repeat (6) mem_cycle(0, 0, 0, 0, 0, 0, "drain");
        chk(exp0_q.size() == 0, "R9 all responses returned", exp0_q.size(), 0);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; dll_off_i = 1'b0;
        rd_valid_i = 1'b0; wr_valid_i = 1'b0;
        rd_addr_i = '0; wr_addr_i = '0; wr_data0_i = '0; wr_data1_i = '0;
        run_mode(1'b0);
        run_mode(1'b1);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
        $finish;
    end

endmodule